// File: doc/BRIEF.md
# Reset-Time Boot ROM Overlay

After a system reset this block lays a 32-byte boot program over the bottom of memory. While it is armed, every memory read cycle on the bus pulls the active-low overlay line. That line tells the normal memory boards to stay off the data bus, and the block places the boot byte selected by address bits 4:0 there instead. The boot program starts a disk read of sector 1 into memory at address 0. It then jumps to the second-stage loader, or halts if the disk reports an error.

The overlay switches itself off when the processor fetches an opcode with address bit 5 set, which is the first fetch beyond the 32-byte window. It stays off until the next reset. A strap input can defeat the overlay. The disk port base is a parameter, and the port numbers inside the boot bytes are computed from it.

Top module: `boot_overlay`

## Requirements
- R1: While `rst_ni` is low the overlay is armed. After reset is released with `boot_en_i` high, a memory read cycle is overlaid.
- R2: The overlay drives only in cycles with both `smemr_i` and `pdbin_i` high. Memory writes, I/O reads and idle cycles leave it inactive. Inactive means `phantom_no`=1, `rom_cs_no`=1, `data_oe_o`=0 and `data_o`=0.
- R3: A cycle with `addr_i[5]`, `phase1_i`, `psync_i` and `sfetch_i` all high turns the overlay off. That cycle itself is not overlaid, and the overlay stays off until the next reset.
- R4: The turn-off condition needs all four terms. With any one of them low, the overlay stays armed, including during opcode fetches from addresses 0 to 31.
- R5: Only `addr_i[4:0]` selects the ROM byte. Outside the turn-off condition, a read with bit 5 set returns the same byte as the read with bit 5 clear.
- R6: With port base B, the bytes at indices 0x00 to 0x1F are: DB B+4 AF 6F 67 3C D3 B+2 3E 8C D3 B DB B+4 B7 F2 19 00 DB B+3 77 23 C3 0C 00 DB B B7 CA 7D 00 76 (hex).
- R7: An overlaid read gives `phantom_no`=0, `rom_cs_no`=0 and `data_oe_o`=1.
- R8: With `boot_en_i` low the overlay is inactive in that same cycle, and it is disarmed at the next clock edge. Raising `boot_en_i` again does not rearm it. Only a reset taken with `boot_en_i` high rearms it.
- R9: `PORT_BASE` (default 0xF8) sets the port bytes of R6. With base 0x78 the bytes at indices 0x01, 0x07, 0x0B, 0x0D, 0x13 and 0x1A are 7C, 7A, 78, 7C, 7B and 78.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset; arms the overlay |
| boot_en_i | input | 1 | Strap; low defeats the overlay |
| smemr_i | input | 1 | Memory read status |
| pdbin_i | input | 1 | Data-in strobe |
| phase1_i | input | 1 | Phase-1 clock qualifier |
| psync_i | input | 1 | Cycle-start sync |
| sfetch_i | input | 1 | Opcode fetch status |
| addr_i | input | 6 | Address bits 5:0 |
| phantom_no | output | 1 | Active-low memory suppression |
| rom_cs_no | output | 1 | Active-low ROM select |
| data_o | output | 8 | Boot byte, zero when not driving |
| data_oe_o | output | 1 | Data bus drive enable |

## Verification
The assertions watch three things on every cycle. The overlay line is only asserted in memory read cycles. The data is zero whenever the overlay is inactive. Once a turn-off cycle occurs, the armed state stays cleared and is never regained without a reset. Only the bench scenarios can show the rest: that every byte of the table is correct for both port bases, and that bit 5 aliases the window. The bench also shows that each partial turn-off condition leaves the overlay armed, and how the strap and reset interact.

// File: rtl/boot_ovl_pkg.sv
package boot_ovl_pkg;
  localparam int unsigned ROM_DEPTH = 32;
  localparam int unsigned IDX_W     = $clog2(ROM_DEPTH);

  localparam logic [7:0] OFS_CMD  = 8'd0;
  localparam logic [7:0] OFS_SECT = 8'd2;
  localparam logic [7:0] OFS_DATA = 8'd3;
  localparam logic [7:0] OFS_WAIT = 8'd4;

  typedef struct packed {
    logic rd;
    logic kill;
  } bus_dec_t;

  function automatic logic [7:0] boot_byte(input logic [IDX_W-1:0] idx,
                                           input logic [7:0] base,
                                           input logic [7:0] cmd,
                                           input logic [15:0] entry);
    logic [7:0] b;
    case (idx)
      5'h00: b = 8'hDB;              // in wait
      5'h01: b = base + OFS_WAIT;
      5'h02: b = 8'hAF;              // xra a
      5'h03: b = 8'h6F;              // mov l,a
      5'h04: b = 8'h67;              // mov h,a
      5'h05: b = 8'h3C;              // inr a -> sector 1
      5'h06: b = 8'hD3;              // out sector
      5'h07: b = base + OFS_SECT;
      5'h08: b = 8'h3E;              // mvi a,cmd
      5'h09: b = cmd;
      5'h0A: b = 8'hD3;              // out command
      5'h0B: b = base + OFS_CMD;
      5'h0C: b = 8'hDB;              // loop: in wait
      5'h0D: b = base + OFS_WAIT;
      5'h0E: b = 8'hB7;              // ora a
      5'h0F: b = 8'hF2;              // jp done (bit7 low)
      5'h10: b = 8'h19;
      5'h11: b = 8'h00;
      5'h12: b = 8'hDB;              // in data
      5'h13: b = base + OFS_DATA;
      5'h14: b = 8'h77;              // mov m,a
      5'h15: b = 8'h23;              // inx h
      5'h16: b = 8'hC3;              // jmp loop
      5'h17: b = 8'h0C;
      5'h18: b = 8'h00;
      5'h19: b = 8'hDB;              // done: in status
      5'h1A: b = base + OFS_CMD;
      5'h1B: b = 8'hB7;              // ora a
      5'h1C: b = 8'hCA;              // jz entry
      5'h1D: b = entry[7:0];
      5'h1E: b = entry[15:8];
      default: b = 8'h76;            // hlt
    endcase
    return b;
  endfunction
endpackage

// File: rtl/ovl_bus_decode.sv
module ovl_bus_decode
  import boot_ovl_pkg::*;
#(
  parameter int unsigned KILL_BIT = 5
) (
  input  logic                smemr_i,
  input  logic                pdbin_i,
  input  logic                phase1_i,
  input  logic                psync_i,
  input  logic                sfetch_i,
  input  logic [KILL_BIT:0]   addr_i,
  output bus_dec_t            dec_o
);
  always_comb begin
    dec_o.rd   = smemr_i & pdbin_i;
    dec_o.kill = addr_i[KILL_BIT] & phase1_i & psync_i & sfetch_i;
  end
endmodule

// File: rtl/ovl_arm.sv
module ovl_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_i,
  input  logic kill_i,
  output logic armed_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                armed_q <= 1'b1;
    else if (kill_i || !strap_i) armed_q <= 1'b0;
  end

  assign armed_o = armed_q;

  a_r3_kill_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> !armed_q);
  a_r8_strap_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strap_i |=> !armed_q);
  a_r3_off_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> !armed_q);
endmodule

// File: rtl/ovl_rom.sv
module ovl_rom
  import boot_ovl_pkg::*;
#(
  parameter logic [7:0]  PORT_BASE = 8'hF8,
  parameter logic [7:0]  READ_CMD  = 8'h8C,
  parameter logic [15:0] ENTRY     = 16'h007D
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic             sel_i,
  output logic [7:0]       data_o
);
  logic [7:0] table_w [ROM_DEPTH];

  for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_byte
    assign table_w[g] = boot_byte(IDX_W'(g), PORT_BASE, READ_CMD, ENTRY);
  end

  assign data_o = sel_i ? table_w[idx_i] : 8'h00;
endmodule

// File: rtl/boot_overlay.sv
module boot_overlay
  import boot_ovl_pkg::*;
#(
  parameter logic [7:0]  PORT_BASE = 8'hF8,
  parameter logic [7:0]  READ_CMD  = 8'h8C,
  parameter logic [15:0] ENTRY     = 16'h007D
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       boot_en_i,
  input  logic       smemr_i,
  input  logic       pdbin_i,
  input  logic       phase1_i,
  input  logic       psync_i,
  input  logic       sfetch_i,
  input  logic [5:0] addr_i,
  output logic       phantom_no,
  output logic       rom_cs_no,
  output logic [7:0] data_o,
  output logic       data_oe_o
);
  localparam int unsigned KILL_BIT = IDX_W;

  bus_dec_t dec;
  logic     armed;
  logic     live;

  ovl_bus_decode #(.KILL_BIT(KILL_BIT)) u_dec (
    .smemr_i (smemr_i),
    .pdbin_i (pdbin_i),
    .phase1_i(phase1_i),
    .psync_i (psync_i),
    .sfetch_i(sfetch_i),
    .addr_i  (addr_i),
    .dec_o   (dec)
  );

  ovl_arm u_arm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .strap_i(boot_en_i),
    .kill_i (dec.kill),
    .armed_o(armed)
  );

  // the exit fetch itself must come from system memory
  assign live = armed & boot_en_i & dec.rd & ~dec.kill;

  ovl_rom #(.PORT_BASE(PORT_BASE), .READ_CMD(READ_CMD), .ENTRY(ENTRY)) u_rom (
    .idx_i (addr_i[IDX_W-1:0]),
    .sel_i (live),
    .data_o(data_o)
  );

  assign phantom_no = ~live;
  assign rom_cs_no  = ~live;
  assign data_oe_o  = live;

  a_r2_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phantom_no |-> (smemr_i && pdbin_i));
  a_r2_idle_data_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phantom_no |-> (data_o == 8'h00));
  a_r3_exit_not_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[5] && phase1_i && psync_i && sfetch_i) |-> (phantom_no && !data_oe_o));
  a_r8_strap_low_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boot_en_i |-> phantom_no);
endmodule

// File: tb/tb_boot_overlay.sv
module tb_boot_overlay;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_en = 1'b1;
  logic smemr = 0, pdbin = 0, ph1 = 0, psync = 0, sfetch = 0;
  logic [5:0] addr = '0;
  logic phantom_n, cs_n, oe, phantom_n2, cs_n2, oe2;
  logic [7:0] data, data2;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  boot_overlay dut (
    .clk_i(clk), .rst_ni(rst_n), .boot_en_i(boot_en), .smemr_i(smemr),
    .pdbin_i(pdbin), .phase1_i(ph1), .psync_i(psync), .sfetch_i(sfetch),
    .addr_i(addr), .phantom_no(phantom_n), .rom_cs_no(cs_n),
    .data_o(data), .data_oe_o(oe));

  boot_overlay #(.PORT_BASE(8'h78)) dut_alt (
    .clk_i(clk), .rst_ni(rst_n), .boot_en_i(boot_en), .smemr_i(smemr),
    .pdbin_i(pdbin), .phase1_i(ph1), .psync_i(psync), .sfetch_i(sfetch),
    .addr_i(addr), .phantom_no(phantom_n2), .rom_cs_no(cs_n2),
    .data_o(data2), .data_oe_o(oe2));

  function automatic logic [7:0] exp_byte(input int i, input logic [7:0] b);
    logic [7:0] t [32];
    t = '{8'hDB, b+8'd4, 8'hAF, 8'h6F, 8'h67, 8'h3C, 8'hD3, b+8'd2,
          8'h3E, 8'h8C, 8'hD3, b, 8'hDB, b+8'd4, 8'hB7, 8'hF2,
          8'h19, 8'h00, 8'hDB, b+8'd3, 8'h77, 8'h23, 8'hC3, 8'h0C,
          8'h00, 8'hDB, b, 8'hB7, 8'hCA, 8'h7D, 8'h00, 8'h76};
    return t[i];
  endfunction

  // packed view {phantom_n, cs_n, oe, data}
  function automatic logic [10:0] on_word(input logic [7:0] d);
    return {1'b0, 1'b0, 1'b1, d};
  endfunction
  localparam logic [10:0] OFF_WORD = {1'b1, 1'b1, 1'b0, 8'h00};

  task automatic check(input string req, input logic [10:0] got, input logic [10:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h exp=%h (t=%0t)", req, got, exp, $time);
    end
  endtask

  task automatic cyc(input logic m, input logic d, input logic p1, input logic ps,
                     input logic f, input logic [5:0] a);
    @(negedge clk);
    smemr = m; pdbin = d; ph1 = p1; psync = ps; sfetch = f; addr = a;
    #5;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    smemr = 0; pdbin = 0; ph1 = 0; psync = 0; sfetch = 0; addr = '0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog: got=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    cyc(0, 0, 0, 0, 0, 6'd0);
    check("R2 idle after reset", {phantom_n, cs_n, oe, data}, OFF_WORD);
    cyc(1, 1, 0, 0, 0, 6'd0);
    check("R1 armed after reset", {phantom_n, cs_n, oe, data}, on_word(8'hDB));

    // full read sweep, bit 5 aliases; both bases
    for (int a = 0; a < 64; a++) begin
      cyc(1, 1, 0, 0, 0, 6'(a));
      check("R5 R6 R7 read base F8", {phantom_n, cs_n, oe, data}, on_word(exp_byte(a % 32, 8'hF8)));
      check("R9 read base 78", {phantom_n2, cs_n2, oe2, data2}, on_word(exp_byte(a % 32, 8'h78)));
    end

    // non-read cycles stay quiet
    for (int a = 0; a < 64; a++) begin
      cyc(0, 0, 0, 0, 0, 6'(a));
      check("R2 write/idle", {phantom_n, cs_n, oe, data}, OFF_WORD);
      cyc(0, 1, 0, 0, 0, 6'(a));
      check("R2 io read", {phantom_n, cs_n, oe, data}, OFF_WORD);
      cyc(1, 0, 0, 0, 0, 6'(a));
      check("R2 smemr without pdbin", {phantom_n, cs_n, oe, data}, OFF_WORD);
    end

    // fetches inside the window keep it armed
    for (int a = 0; a < 32; a++) begin
      cyc(1, 1, 1, 1, 1, 6'(a));
      check("R4 fetch in window", {phantom_n, cs_n, oe, data}, on_word(exp_byte(a, 8'hF8)));
    end

    // partial exit conditions
    for (int k = 0; k < 3; k++) begin
      cyc(1, 1, k != 0, k != 1, k != 2, 6'h25);
      check("R4 partial exit same cycle", {phantom_n, cs_n, oe, data}, on_word(exp_byte(5, 8'hF8)));
      cyc(1, 1, 0, 0, 0, 6'd0);
      check("R4 partial exit next cycle", {phantom_n, cs_n, oe, data}, on_word(8'hDB));
    end

    // real exit fetch
    cyc(1, 1, 1, 1, 1, 6'h20);
    check("R3 exit cycle not overlaid", {phantom_n, cs_n, oe, data}, OFF_WORD);
    check("R3 exit cycle alt", {phantom_n2, cs_n2, oe2, data2}, OFF_WORD);
    for (int a = 0; a < 64; a++) begin
      cyc(1, 1, 0, 0, 0, 6'(a));
      check("R3 stays off", {phantom_n, cs_n, oe, data}, OFF_WORD);
    end

    do_reset();
    cyc(1, 1, 0, 0, 0, 6'h1F);
    check("R1 rearmed by reset", {phantom_n, cs_n, oe, data}, on_word(8'h76));

    // strap
    @(negedge clk);
    boot_en = 1'b0;
    cyc(1, 1, 0, 0, 0, 6'd9);
    check("R8 strap low immediate", {phantom_n, cs_n, oe, data}, OFF_WORD);
    @(negedge clk);
    boot_en = 1'b1;
    cyc(1, 1, 0, 0, 0, 6'd9);
    check("R8 strap raise no rearm", {phantom_n, cs_n, oe, data}, OFF_WORD);
    boot_en = 1'b0;
    do_reset();
    cyc(1, 1, 0, 0, 0, 6'd9);
    check("R8 reset with strap low", {phantom_n, cs_n, oe, data}, OFF_WORD);
    @(negedge clk);
    boot_en = 1'b1;
    do_reset();
    cyc(1, 1, 0, 0, 0, 6'd9);
    check("R1 R8 reset with strap high", {phantom_n, cs_n, oe, data}, on_word(8'h8C));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule